// File: doc/BRIEF.md
# YUV 4:2:2 Output Bus Formatter

This block packs line-locked luminance and colour-difference samples into a 16-bit digital video bus. One byte lane carries luminance. The other byte lane carries the two colour-difference components, time-multiplexed. The block runs on the fast line-locked clock. It generates a clock-reference qualifier, `cref_o`, that is high on every second clock cycle, so the bus moves at half the clock rate.

A word is transferred only on a rising clock edge that ends a cycle in which `cref_o` is high. The source presents one full 4:4:4 sample (Y, U, V) per transfer. The block averages each pair of horizontally adjacent chroma samples, so the bus carries one U and one V for every two luminance samples. A horizontal reference input frames the active samples, and the bus carries blanking codes outside that window.

An active-low fast-enable input drives the output enable directly, with no register on that path. When it is high, both byte lanes go to high impedance. The enable has no effect on the data path or on any phase.

Top module: `yuv422_bus_fmt`

## Requirements
- R1: A synchronous active-high reset clears `cref_o` to 0, sets `y_o` to 0x10 and `uv_o` to 0x80, and restarts the chroma pairing and the U/V lane phase.
- R2: `cref_o` toggles on every clock edge after reset. `y_o` and `uv_o` change only on an edge that ends a cycle with `cref_o` high, which is a qualified edge.
- R3: A word whose inputs are captured on qualified edge k appears on the outputs just after qualified edge k+2, which is four clock cycles later.
- R4: During active output words, `y_o` carries the captured luminance samples in their input order.
- R5: Within a line, the first active output word carries U on `uv_o`. The lane then alternates V, U, V. The phase restarts whenever the reference input has been low.
- R6: Chroma words are counted from 0 at the start of each line, and words 2p and 2p+1 form a pair. The U sent for the pair equals (U[2p]+U[2p+1]+1)>>1, computed without overflow, and the V sent equals the same formula applied to V.
- R7: An output word whose source word was captured while `href_i` was low shows `y_o`=0x10 and `uv_o`=0x80.
- R8: `oe_o` equals the inverse of `fein_n_i` in the same cycle, with no clock edge involved. A high `fein_n_i` puts `y_o` and `uv_o` at high impedance and leaves the data path and all phases unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock (fast rate) |
| rst | input | 1 | Synchronous active-high reset |
| href_i | input | 1 | Horizontal reference; high marks active samples |
| fein_n_i | input | 1 | Fast enable, active low |
| y_i | input | 8 | Luminance sample |
| u_i | input | 8 | B-Y sample |
| v_i | input | 8 | R-Y sample |
| cref_o | output | 1 | Transfer qualifier, high on alternate cycles |
| oe_o | output | 1 | Bus output enable |
| y_o | output | 8 | Luminance lane (tri-state) |
| uv_o | output | 8 | Multiplexed chroma lane (tri-state) |

## Verification
`cref_o` falls on each qualified edge, and a word captured on qualified edge k is due just after qualified edge k+2, four clock cycles later. The bench presents each input word at the falling edge inside a `cref_o`-high cycle. It compares the lanes at the next falling edge against the source word two transfers earlier, and it confirms there that `cref_o` is low. The bench compares `oe_o` one nanosecond after `fein_n_i` moves, so the check shows that no clock edge is involved. It checks blanking and reset values on the first falling edge after the edge that should produce them.

// File: rtl/yuv422_pkg.sv
package yuv422_pkg;
   typedef enum logic {PH_U = 1'b0, PH_V = 1'b1} uv_phase_e;
   localparam int unsigned PIPE_WORDS = 2;
endpackage

// File: rtl/y422_qual_gen.sv
module y422_qual_gen (
   input  logic clk,
   input  logic rst,
   output logic cref,
   output logic adv
);
   always_ff @(posedge clk) begin
      if (rst) cref <= 1'b0;
      else     cref <= ~cref;
   end

   // an edge is a transfer edge when the qualifier was high during the cycle
   assign adv = cref;

   p_cref_toggle_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (cref != $past(cref)));
endmodule

// File: rtl/y422_chroma_sub.sv
module y422_chroma_sub #(
   parameter int unsigned W        = 8,
   parameter bit          ROUND_UP = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   input  logic         act,
   input  logic         odd,
   input  logic [W-1:0] c_i,
   output logic [W-1:0] c_avg
);
   localparam int unsigned SW = W + 1;

   logic [W-1:0]  first_q;
   logic [SW-1:0] sum;
   logic          rnd;

   generate
      if (ROUND_UP) begin : g_round
         assign rnd = 1'b1;
      end else begin : g_trunc
         assign rnd = 1'b0;
      end
   endgenerate

   assign sum = {1'b0, first_q} + {1'b0, c_i} + {{(SW-1){1'b0}}, rnd};

   always_ff @(posedge clk) begin
      if (rst) begin
         first_q <= '0;
         c_avg   <= '0;
      end else if (adv && act) begin
         if (!odd) first_q <= c_i;
         else      c_avg   <= sum[SW-1:1];
      end
   end

   p_avg_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !($past(adv) && $past(act) && $past(odd)) |-> $stable(c_avg));
endmodule

// File: rtl/y422_core.sv
module y422_core
   import yuv422_pkg::*;
#(
   parameter int unsigned W        = 8,
   parameter logic [W-1:0] Y_BLANK = 8'h10,
   parameter logic [W-1:0] C_BLANK = 8'h80,
   parameter bit          ROUND_UP = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         href_i,
   input  logic         fein_n_i,
   input  logic [W-1:0] y_i,
   input  logic [W-1:0] u_i,
   input  logic [W-1:0] v_i,
   output logic         cref_o,
   output logic         oe_o,
   output logic [W-1:0] y_q,
   output logic [W-1:0] uv_q
);
   localparam int unsigned NCOMP = 2;

   generate
      if (W < 2) begin : g_bad_w
         $error("y422_core: W must be at least 2");
      end
   endgenerate

   logic         adv;
   logic         in_odd;
   logic [W-1:0] yd [PIPE_WORDS];
   logic [PIPE_WORDS-1:0] hd;
   logic         out_act;
   uv_phase_e    out_ph;
   logic [W-1:0] c_in  [NCOMP];
   logic [W-1:0] c_avg [NCOMP];

   y422_qual_gen u_qual (
      .clk  (clk),
      .rst  (rst),
      .cref (cref_o),
      .adv  (adv)
   );

   assign c_in[0] = u_i;
   assign c_in[1] = v_i;

   generate
      for (genvar gi = 0; gi < NCOMP; gi++) begin : g_comp
         y422_chroma_sub #(.W(W), .ROUND_UP(ROUND_UP)) u_sub (
            .clk   (clk),
            .rst   (rst),
            .adv   (adv),
            .act   (href_i),
            .odd   (in_odd),
            .c_i   (c_in[gi]),
            .c_avg (c_avg[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         in_odd  <= 1'b0;
         hd      <= '0;
         for (int i = 0; i < PIPE_WORDS; i++) yd[i] <= '0;
         out_act <= 1'b0;
         out_ph  <= PH_U;
         y_q     <= Y_BLANK;
         uv_q    <= C_BLANK;
      end else if (adv) begin
         in_odd <= href_i ? ~in_odd : 1'b0;
         yd[0]  <= y_i;
         hd[0]  <= href_i;
         for (int i = 1; i < PIPE_WORDS; i++) begin
            yd[i] <= yd[i-1];
            hd[i] <= hd[i-1];
         end
         out_act <= hd[PIPE_WORDS-1];
         if (hd[PIPE_WORDS-1]) begin
            y_q    <= yd[PIPE_WORDS-1];
            uv_q   <= (out_ph == PH_V) ? c_avg[1] : c_avg[0];
            out_ph <= (out_ph == PH_U) ? PH_V : PH_U;
         end else begin
            y_q    <= Y_BLANK;
            uv_q   <= C_BLANK;
            out_ph <= PH_U;
         end
      end
   end

   // fast enable: no register between the pin and the drivers
   assign oe_o = ~fein_n_i;

   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(cref_o) |-> ($stable(y_q) && $stable(uv_q)));

   p_blank_r7: assert property (@(posedge clk) disable iff (rst)
      ($past(adv) && !$past(hd[PIPE_WORDS-1])) |-> (y_q == Y_BLANK && uv_q == C_BLANK));

   p_u_first_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(out_act) |-> (out_ph == PH_V));

   p_reset_r1: assert property (@(posedge clk)
      $past(rst) |-> (!cref_o && y_q == Y_BLANK && uv_q == C_BLANK && out_ph == PH_U));
endmodule

// File: rtl/yuv422_bus_fmt.sv
module yuv422_bus_fmt #(
   parameter int unsigned W        = 8,
   parameter logic [W-1:0] Y_BLANK = 8'h10,
   parameter logic [W-1:0] C_BLANK = 8'h80,
   parameter bit          ROUND_UP = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         href_i,
   input  logic         fein_n_i,
   input  logic [W-1:0] y_i,
   input  logic [W-1:0] u_i,
   input  logic [W-1:0] v_i,
   output logic         cref_o,
   output logic         oe_o,
   output tri   [W-1:0] y_o,
   output tri   [W-1:0] uv_o
);
   logic [W-1:0] y_q;
   logic [W-1:0] uv_q;

   y422_core #(.W(W), .Y_BLANK(Y_BLANK), .C_BLANK(C_BLANK), .ROUND_UP(ROUND_UP)) u_core (
      .clk      (clk),
      .rst      (rst),
      .href_i   (href_i),
      .fein_n_i (fein_n_i),
      .y_i      (y_i),
      .u_i      (u_i),
      .v_i      (v_i),
      .cref_o   (cref_o),
      .oe_o     (oe_o),
      .y_q      (y_q),
      .uv_q     (uv_q)
   );

   assign y_o  = oe_o ? y_q  : {W{1'bz}};
   assign uv_o = oe_o ? uv_q : {W{1'bz}};
endmodule

// File: tb/yuv422_bus_fmt_tb.sv
`timescale 1ns/1ps
module yuv422_bus_fmt_tb;
   localparam int NV = 30;
   localparam int SEG_B = 22;

   // {fein_n, href, y, u, v}
   localparam logic [25:0] VEC [NV] = '{
      {1'b0,1'b0,8'h00,8'h00,8'h00}, {1'b0,1'b0,8'h11,8'h22,8'h33},
      {1'b0,1'b1,8'h20,8'h01,8'h10}, {1'b0,1'b1,8'h21,8'h02,8'h20},
      {1'b0,1'b1,8'h22,8'hFF,8'h03}, {1'b0,1'b1,8'h23,8'hFF,8'h04},
      {1'b0,1'b1,8'h24,8'h00,8'hF0}, {1'b0,1'b1,8'h25,8'h01,8'h0F},
      {1'b0,1'b1,8'h26,8'h80,8'h55}, {1'b0,1'b1,8'h27,8'h7F,8'h56},
      {1'b0,1'b0,8'h99,8'h99,8'h99}, {1'b0,1'b0,8'h98,8'h98,8'h98},
      {1'b0,1'b1,8'hEB,8'h40,8'hC0}, {1'b0,1'b1,8'h10,8'h42,8'hC3},
      {1'b1,1'b1,8'h55,8'h08,8'h09}, {1'b1,1'b1,8'hAA,8'h0B,8'h0C},
      {1'b0,1'b1,8'h01,8'hF1,8'h11}, {1'b0,1'b1,8'hFE,8'hF2,8'h12},
      {1'b0,1'b0,8'h00,8'h00,8'h00}, {1'b0,1'b0,8'h00,8'h00,8'h00},
      {1'b0,1'b0,8'h00,8'h00,8'h00}, {1'b0,1'b0,8'h00,8'h00,8'h00},
      {1'b0,1'b1,8'h31,8'h05,8'h06}, {1'b0,1'b1,8'h32,8'h07,8'h09},
      {1'b0,1'b1,8'h33,8'hA0,8'h60}, {1'b0,1'b1,8'h34,8'hA1,8'h61},
      {1'b0,1'b0,8'h00,8'h00,8'h00}, {1'b0,1'b0,8'h00,8'h00,8'h00},
      {1'b0,1'b0,8'h00,8'h00,8'h00}, {1'b0,1'b0,8'h00,8'h00,8'h00}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       href_i = 1'b0;
   logic       fein_n_i = 1'b0;
   logic [7:0] y_i = '0, u_i = '0, v_i = '0;
   logic       cref_o, oe_o;
   wire  [7:0] y_o, uv_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   int pos [NV];

   always #10 clk = ~clk;

   yuv422_bus_fmt u_dut (
      .clk(clk), .rst(rst), .href_i(href_i), .fein_n_i(fein_n_i),
      .y_i(y_i), .u_i(u_i), .v_i(v_i),
      .cref_o(cref_o), .oe_o(oe_o), .y_o(y_o), .uv_o(uv_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic int avg2(input int a, input int b);
      return (a + b + 1) / 2;
   endfunction

   task automatic run_vectors(input int lo, input int hi);
      int prev_y, prev_uv;
      prev_y = 8'h10; prev_uv = 8'h80;
      for (int i = lo; i < hi; i++) begin
         logic [25:0] vv;
         vv = VEC[i];
         do @(negedge clk); while (cref_o !== 1'b1);
         fein_n_i = vv[25]; href_i = vv[24];
         y_i = vv[23:16]; u_i = vv[15:8]; v_i = vv[7:0];
         pos[i] = (vv[24] && i > lo && VEC[i-1][24]) ? pos[i-1] + 1 : 0;
         #1;
         check("R8 oe immediate", int'(oe_o), int'(!vv[25]));
         if (!vv[25] && i > lo && !VEC[i-1][25]) begin
            check("R2 hold y", int'(y_o), prev_y);
            check("R2 hold uv", int'(uv_o), prev_uv);
         end
         @(posedge clk);
         @(negedge clk);
         check("R2 cref low after transfer edge", int'(cref_o), 0);
         if (!vv[25]) begin
            int s, ey, euv, b;
            s = i - 2;
            if (s < lo || !VEC[s][24]) begin
               ey = 8'h10; euv = 8'h80;
               check("R7 blank y", int'(y_o), ey);
               check("R7 blank uv", int'(uv_o), euv);
            end else begin
               b  = s - (pos[s] % 2);
               ey = int'(VEC[s][23:16]);
               if (pos[s] % 2 == 0) euv = avg2(VEC[b][15:8], VEC[b+1][15:8]);
               else                 euv = avg2(VEC[b][7:0],  VEC[b+1][7:0]);
               check("R3 R4 luma lane", int'(y_o), ey);
               check("R5 R6 chroma lane", int'(uv_o), euv);
            end
            prev_y = int'(y_o); prev_uv = int'(uv_o);
         end
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset cref", int'(cref_o), 0);
      check("R1 reset y", int'(y_o), 8'h10);
      check("R1 reset uv", int'(uv_o), 8'h80);
      rst = 1'b0;
      @(negedge clk);
      check("R2 cref toggles", int'(cref_o), 1);
      @(negedge clk);
      check("R2 cref toggles", int'(cref_o), 0);

      run_vectors(0, SEG_B);

      // mid-line reset: the line must restart with U
      href_i = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         y_i = 8'h70 + 8'(k); u_i = 8'h3C; v_i = 8'hC3;
      end
      rst = 1'b1;
      href_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R1 mid-line reset cref", int'(cref_o), 0);
      check("R1 mid-line reset y", int'(y_o), 8'h10);
      check("R1 mid-line reset uv", int'(uv_o), 8'h80);
      rst = 1'b0;

      run_vectors(SEG_B, NV);

      // fast enable toggled between clock edges
      @(negedge clk);
      #3 fein_n_i = 1'b1;
      #1 check("R8 oe drops without clock", int'(oe_o), 0);
      #2 fein_n_i = 1'b0;
      #1 check("R8 oe rises without clock", int'(oe_o), 1);
      check("R8 data unchanged y", int'(y_o), 8'h10);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule